// File: doc/BRIEF.md
# Nibble-Mode Burst Address Sequencer

This block chooses which of four bits, all sharing one row and one column, a multiplexed-address memory reaches during a nibble burst. When the row strobe falls, the top address bit is captured. When the first column strobe falls, the top address bit is captured again. Together the two captured bits form a 2-bit starting selector, and the row-captured bit is its least significant bit. After that, each falling column strobe inside the same row-strobe-low period moves the selector on by one, modulo four. The sequence therefore visits all four bits and returns to the first one, and it keeps circling until the row strobe rises.

The block also classifies each access. An access is a write if the write strobe is low when the column strobe falls (early write). It also becomes a write if the write strobe falls later while the column strobe is still low (delayed write). Otherwise the access is a read, and the output enable of the tri-stated data pin is raised. The strobes are active-low and are sampled on a system clock, and edges are found by comparing each sample with the previous one. The cell array and analog timing lie outside this block.

Top module: `nib_burst_seq`

## Requirements
- R1: While `rst` is high and after it falls, `sel`=0, `acc_active`=0, `acc_write`=0 and `dout_oe`=0 until a strobe edge is sampled.
- R2: A row burst opens when `ras_n` is sampled falling while `cas_n` is sampled high, and `addr_hi` is captured as bit 0. At the first `cas_n` fall after that, `addr_hi` is captured as bit 1. From the edge that samples this fall, `sel` = {column bit, row bit}.
- R3: Every later `cas_n` fall in the same burst adds 1 (mod 4) to `sel` at the edge that samples it, and `addr_hi` is ignored for those accesses.
- R4: The fifth access of a burst shows the same `sel` as the first, so the sequence wraps.
- R5: The edge that samples `ras_n` rising clears `sel` to 0. The next burst captures a new start offset.
- R6: If `we_n` is sampled low in the same cycle as a `cas_n` fall, the access is an early write: `acc_write`=1 and `dout_oe` stays 0 for the whole access.
- R7: If `we_n` is sampled high at a `cas_n` fall in an open burst, the access is a read, and `dout_oe`=1 from that edge.
- R8: A `we_n` fall sampled during an active access sets `acc_write`=1 at that edge and leaves `dout_oe` unchanged (delayed write).
- R9: The edge that samples `cas_n` rising clears `acc_active`, `acc_write` and `dout_oe`, so the data pin is high-impedance whenever `cas_n` is high.
- R10: A `cas_n` fall while no burst is open causes no access: `acc_active` stays 0 and `sel` does not change. This covers `ras_n` high, and `ras_n` having fallen while `cas_n` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr_hi | input | 1 | Top address bit |
| sel | output | 2 | Selected bit of the four-bit group |
| acc_active | output | 1 | An access within an open burst is in progress |
| acc_write | output | 1 | Current access is a write |
| dout_oe | output | 1 | Output enable for the tri-stated data pin |

## Verification
Two decisions can fall in the same sampled cycle: a column-strobe fall and a write-strobe fall. If they do, the access must be treated as an early write and the output enable must never rise. The bench provokes this by lowering `cas_n` and `we_n` together before one edge, then checks that `acc_write` is high and `dout_oe` is low. A second case pairs a row-strobe fall with a column strobe that is already low, and the bench judges it by the absence of any access on the next column fall.

// File: rtl/nib_pkg.sv
package nib_pkg;
    parameter int NIB_DEPTH = 4;
    localparam int SEL_W = $clog2(NIB_DEPTH);

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic we;
        logic cas;
        logic ras;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

    function automatic sel_t nib_step(input sel_t s);
        return sel_t'(s + sel_t'(1));
    endfunction

    function automatic sel_t nib_start(input logic col_bit, input logic row_bit);
        return sel_t'({col_bit, row_bit});
    endfunction
endpackage

// File: rtl/nib_edge_det.sv
module nib_edge_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign fall[i] = prev_q[i] & ~lvl[i];
        assign rise[i] = ~prev_q[i] & lvl[i];
    end
endmodule

// File: rtl/nib_ptr.sv
module nib_ptr
    import nib_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ras_fall,
    input  logic ras_rise,
    input  logic cas_fall,
    input  logic cas_lvl,
    input  logic addr_hi,
    output sel_t sel,
    output logic acc_go
);
    logic open_q, started_q, row_q, col_q;
    sel_t cnt_q;

    assign acc_go = cas_fall & open_q & ~ras_rise;
    assign sel    = sel_t'(nib_start(col_q, row_q) + cnt_q);

    always_ff @(posedge clk) begin
        if (rst || ras_rise) begin
            open_q    <= 1'b0;
            started_q <= 1'b0;
            row_q     <= 1'b0;
            col_q     <= 1'b0;
            cnt_q     <= '0;
        end else if (ras_fall) begin
            open_q <= cas_lvl;
            if (cas_lvl) row_q <= addr_hi;
        end else if (acc_go) begin
            if (!started_q) begin
                col_q     <= addr_hi;
                started_q <= 1'b1;
            end else begin
                cnt_q <= nib_step(cnt_q);
            end
        end
    end

    // R5
    burst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ras_rise |=> (cnt_q == '0 && !started_q && !open_q));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_go && started_q && !ras_fall) |=> (cnt_q == nib_step($past(cnt_q))));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_fall && !ras_rise && !acc_go) |=> $stable(cnt_q) && $stable(col_q));
endmodule

// File: rtl/nib_acc_ctrl.sv
module nib_acc_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic acc_go,
    input  logic cas_rise,
    input  logic we_fall,
    input  logic we_lvl,
    output logic active,
    output logic write,
    output logic oe
);
    logic act_q, wr_q, oe_q;

    always_ff @(posedge clk) begin
        if (rst || cas_rise) begin
            act_q <= 1'b0;
            wr_q  <= 1'b0;
            oe_q  <= 1'b0;
        end else if (acc_go) begin
            act_q <= 1'b1;
            wr_q  <= ~we_lvl;
            oe_q  <= we_lvl;
        end else if (act_q && we_fall) begin
            wr_q <= 1'b1;
        end
    end

    assign active = act_q;
    assign write  = wr_q;
    assign oe     = oe_q;

    // R9
    hiz_on_cas_high_chk: assert property (@(posedge clk) disable iff (rst)
        cas_rise |=> (!oe_q && !wr_q && !act_q));

    // R7
    oe_source_chk: assert property (@(posedge clk) disable iff (rst)
        (!oe_q && !acc_go) |=> !oe_q);

    // R6
    early_write_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_go && !we_lvl) |=> (wr_q && !oe_q));
endmodule

// File: rtl/nib_burst_seq.sv
module nib_burst_seq
    import nib_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             addr_hi,
    output logic [SEL_W-1:0] sel,
    output logic             acc_active,
    output logic             acc_write,
    output logic             dout_oe
);
    strobe_t lvl, fall, rise;
    logic    acc_go;

    assign lvl = '{we: we_n, cas: cas_n, ras: ras_n};

    nib_edge_det #(.W(STROBE_W)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .fall (fall),
        .rise (rise)
    );

    nib_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ras_fall (fall.ras),
        .ras_rise (rise.ras),
        .cas_fall (fall.cas),
        .cas_lvl  (lvl.cas),
        .addr_hi  (addr_hi),
        .sel      (sel),
        .acc_go   (acc_go)
    );

    nib_acc_ctrl u_acc (
        .clk      (clk),
        .rst      (rst),
        .acc_go   (acc_go),
        .cas_rise (rise.cas),
        .we_fall  (fall.we),
        .we_lvl   (lvl.we),
        .active   (acc_active),
        .write    (acc_write),
        .oe       (dout_oe)
    );

    // R8
    delayed_write_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_active && fall.we && !rise.cas) |=> (acc_write && $stable(dout_oe)));
endmodule

// File: tb/sim_nib_burst_seq.sv
module sim_nib_burst_seq;
    logic clk = 0;
    logic rst = 1;
    logic ras_n = 1, cas_n = 1, we_n = 1, addr_hi = 0;
    logic [1:0] sel;
    logic acc_active, acc_write, dout_oe;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    nib_burst_seq u0 (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr_hi(addr_hi), .sel(sel), .acc_active(acc_active),
        .acc_write(acc_write), .dout_oe(dout_oe)
    );

    // {row bit, column bit, expected start selector}
    localparam logic [3:0] VEC [4] = '{4'b0000, 4'b1001, 4'b0110, 4'b1111};

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic open_row(input logic rb);
        addr_hi = rb; ras_n = 0; tick();
    endtask

    task automatic close_row();
        ras_n = 1; cas_n = 1; we_n = 1; tick();
    endtask

    initial begin
        #1ms;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        chk("R1 sel in reset", sel, 0);
        chk("R1 oe in reset", dout_oe, 0);
        rst = 0; tick();
        chk("R1 active after reset", acc_active, 0);
        chk("R1 write after reset", acc_write, 0);

        // Table walk: read bursts of five accesses from each start value
        for (int v = 0; v < 4; v++) begin
            logic [1:0] st;
            st = VEC[v][1:0];
            open_row(VEC[v][3]);
            for (int k = 0; k < 5; k++) begin
                addr_hi = (k == 0) ? VEC[v][2] : ~VEC[v][2];
                cas_n = 0; tick();
                if (k == 0) chk("R2 start selector", sel, st);
                else if (k == 4) chk("R4 wrap to first", sel, st);
                else chk("R3 step", sel, 2'(st + k));
                chk("R7 read oe", dout_oe, 1);
                cas_n = 1; tick();
                chk("R9 oe off cas high", dout_oe, 0);
            end
            close_row();
            chk("R5 cleared on ras rise", sel, 0);
        end

        // Early write: we_n and cas_n fall together
        open_row(1);
        addr_hi = 0; we_n = 0; cas_n = 0; tick();
        chk("R6 early write flag", acc_write, 1);
        chk("R6 early write oe", dout_oe, 0);
        we_n = 1; tick();
        chk("R6 oe stays low", dout_oe, 0);
        cas_n = 1; tick();
        chk("R9 write cleared", acc_write, 0);

        // Delayed write on the second access (mixed burst)
        cas_n = 0; tick();
        chk("R3 second access", sel, 2);
        chk("R7 read before late write", dout_oe, 1);
        chk("R8 read flag", acc_write, 0);
        we_n = 0; tick();
        chk("R8 delayed write flag", acc_write, 1);
        chk("R8 oe unchanged", dout_oe, 1);
        cas_n = 1; we_n = 1; tick();
        chk("R9 active cleared", acc_active, 0);
        chk("R9 oe cleared", dout_oe, 0);
        close_row();

        // R5: new burst re-latches a fresh start
        open_row(0);
        addr_hi = 1; cas_n = 0; tick();
        chk("R5 new start", sel, 2);
        close_row();

        // R10: cas fall with ras high
        addr_hi = 1; cas_n = 0; tick();
        chk("R10 no access ras high", acc_active, 0);
        chk("R10 sel unchanged", sel, 0);
        // R10: ras falls while cas low, then cas cycles
        ras_n = 0; tick();
        cas_n = 1; tick();
        cas_n = 0; tick();
        chk("R10 no burst after cas-first", acc_active, 0);
        chk("R10 oe off", dout_oe, 0);
        chk("R10 sel still zero", sel, 0);
        close_row();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule